// File: doc/BRIEF.md
# Control-Line Mode Selector

This block watches the single control line of a dimmable LED driver and decides what state the device is in. The three states are off, dimming by pulse width, or dimming by serial commands. The line starts out low and the device is off. A rising edge turns the device on and opens a selection window. A low pulse of sufficient length, started late enough inside that window, switches the device into serial-command mode. Without such a pulse the device stays in pulse-width mode, which is the default.

The selected mode holds until the line stays low long enough to turn the device off. The next rising edge starts a fresh selection. Every time limit is a counter threshold, computed from a clock-frequency parameter and a length in microseconds. The raw line passes through a synchroniser before any edge is detected on it.

Top module: `ctrl_mode_detect`

## Requirements
- R1: After reset all three outputs are 0 and the device is off; a low line keeps it off, and a rising edge on the line turns `devEnable` on.
- R2: The selection window opens at the rising edge that turns the device on and lasts `WIN_US` microseconds (1000 by default).
- R3: A low period that begins at least `DLY_US` (100) after the window opens and lasts more than `DET_US` (260) inside the window sets `modeWire` to 1. This happens at once, without waiting for the window to close. A low period of 255 µs does not select the mode.
- R4: When the window closes without that pattern, the device stays on with `modeWire` at 0 (pulse-width mode). This includes a low period that starts too late to reach the detection length before the window ends.
- R5: The chosen mode cannot change while the device is on. A later qualifying low period in pulse-width mode does not select serial mode. After a turn-off and a new start, the mode again defaults to pulse-width.
- R6: A low line held for `OFF_US` (2500) turns the device off and clears `modeWire`. A shorter low period of 2000 µs leaves the device on.
- R7: `rxEnable` is 1 exactly while serial-command mode is latched. Short low bits of 30 µs inside a command stream do not turn the device off.
- R8: A low period that begins before `DLY_US` has elapsed in the window does not count toward detection, however long it lasts within the window.
- R9: A rising edge of `ctrlIn` in the off state shows on `devEnable` after the third rising clock edge, and not after the second. The line passes through two synchroniser stages and the state register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock at `CLK_HZ` |
| rstN | input | 1 | Power-on reset, active low, asynchronous |
| ctrlIn | input | 1 | Raw control line, synchronised inside |
| devEnable | output | 1 | Device on |
| modeWire | output | 1 | 1 = serial-command mode, 0 = pulse-width mode |
| rxEnable | output | 1 | Enable for the serial command receiver |

## Verification
The line is driven with these patterns:
- a steady high, which must end in pulse-width mode;
- a low pulse that starts too early, which tells the delay qualification apart from the plain length test;
- low pulses of 255 and 280 µs started after the delay, which bracket the detection length;
- a pulse that starts at 900 µs, which tests the window edge;
- low stretches of 2000 and 2600 µs, which bracket the turn-off time;
- a burst of short bits in serial mode.

A behavioural reference model that runs on timestamps is compared against the outputs on every clock. Named checks fix the mode after each pattern and the three-edge enable latency.

// File: rtl/ctrl_mode_pkg.sv
package ctrl_mode_pkg;

  typedef enum logic [1:0] {
    ST_SHUT = 2'd0,
    ST_DET  = 2'd1,
    ST_PWM  = 2'd2,
    ST_WIRE = 2'd3
  } pinState_t;

  // datapath -> control
  typedef struct packed {
    logic rise;
    logic wireHit;
    logic winDone;
    logic longLow;
  } pinEvt_t;

  // control -> datapath
  typedef struct packed {
    logic startWin;
  } pinCmd_t;

  function automatic int unsigned usToCycles(input longint unsigned hz, input longint unsigned us);
    return 32'((hz * us) / 64'd1000000);
  endfunction

endpackage

// File: rtl/ctrlpin_timer.sv
module ctrlpin_timer
  import ctrl_mode_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 1000000,
  parameter int unsigned DLY_US      = 100,
  parameter int unsigned DET_US      = 260,
  parameter int unsigned WIN_US      = 1000,
  parameter int unsigned OFF_US      = 2500,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    ctrlIn,
  input  pinCmd_t cmd,
  output pinEvt_t evt
);

  localparam int unsigned DLY_CNT = usToCycles(CLK_HZ, DLY_US);
  localparam int unsigned DET_CNT = usToCycles(CLK_HZ, DET_US);
  localparam int unsigned WIN_CNT = usToCycles(CLK_HZ, WIN_US);
  localparam int unsigned OFF_CNT = usToCycles(CLK_HZ, OFF_US);
  localparam int unsigned CNT_W   = $clog2(OFF_CNT + 1);
  localparam logic [CNT_W-1:0] DLY_C = CNT_W'(DLY_CNT);
  localparam logic [CNT_W-1:0] DET_C = CNT_W'(DET_CNT);
  localparam logic [CNT_W-1:0] WIN_C = CNT_W'(WIN_CNT);
  localparam logic [CNT_W-1:0] OFF_C = CNT_W'(OFF_CNT);

  // synchroniser chain, one flop per stage
  logic [SYNC_STAGES-1:0] syncQ;
  for (genvar g = 0; g < SYNC_STAGES; g++) begin : gSync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)       syncQ[g] <= 1'b0;
      else if (g == 0) syncQ[g] <= ctrlIn;
      else             syncQ[g] <= syncQ[(g == 0) ? 0 : g-1];
    end
  end

  logic lineQ, prevQ;
  assign lineQ = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevQ <= 1'b0;
    else       prevQ <= lineQ;
  end

  logic fallNow;
  assign fallNow = !lineQ && prevQ;

  // time since the window opened, saturating
  logic [CNT_W-1:0] winCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              winCnt <= '0;
    else if (cmd.startWin)  winCnt <= '0;
    else if (winCnt < WIN_C) winCnt <= winCnt + 1'b1;
  end

  // length of the current low run, saturating
  logic [CNT_W-1:0] lowCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               lowCnt <= '0;
    else if (lineQ)          lowCnt <= '0;
    else if (lowCnt < OFF_C) lowCnt <= lowCnt + 1'b1;
  end

  // low run began after the detection delay
  logic lowQual;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             lowQual <= 1'b0;
    else if (cmd.startWin) lowQual <= 1'b0;
    else if (fallNow)      lowQual <= (winCnt >= DLY_C);
  end

  always_comb begin
    evt.rise    = lineQ && !prevQ;
    evt.wireHit = lowQual && !lineQ && (lowCnt > DET_C) && (winCnt < WIN_C);
    evt.winDone = (winCnt >= WIN_C);
    evt.longLow = !lineQ && (lowCnt >= OFF_C);
  end

  assert_win_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    winCnt <= WIN_C);

  assert_low_restart_R6: assert property (@(posedge clk) disable iff (!rstN)
    lineQ |=> (lowCnt == '0));

  assert_qual_after_delay_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lowQual) |-> ($past(winCnt) >= DLY_C));

endmodule

// File: rtl/ctrlpin_fsm.sv
module ctrlpin_fsm
  import ctrl_mode_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  pinEvt_t evt,
  output pinCmd_t cmd,
  output logic    devEnable,
  output logic    modeWire,
  output logic    rxEnable
);

  pinState_t stateQ, stateD;

  always_comb begin
    stateD       = stateQ;
    cmd.startWin = 1'b0;
    unique case (stateQ)
      ST_SHUT: if (evt.rise) begin
        stateD       = ST_DET;
        cmd.startWin = 1'b1;
      end
      ST_DET: begin
        if (evt.longLow)      stateD = ST_SHUT;
        else if (evt.wireHit) stateD = ST_WIRE;
        else if (evt.winDone) stateD = ST_PWM;
      end
      ST_PWM, ST_WIRE: if (evt.longLow) stateD = ST_SHUT;
      default: stateD = ST_SHUT;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_SHUT;
    else       stateQ <= stateD;
  end

  assign devEnable = (stateQ != ST_SHUT);
  assign modeWire  = (stateQ == ST_WIRE);
  assign rxEnable  = (stateQ == ST_WIRE);

  assert_wire_from_window_R3: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_WIRE && $past(stateQ) != ST_WIRE) |-> ($past(stateQ) == ST_DET));

  assert_pwm_locked_R5: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_PWM) |=> (stateQ == ST_PWM || stateQ == ST_SHUT));

  assert_wire_locked_R5: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_WIRE) |=> (stateQ == ST_WIRE || stateQ == ST_SHUT));

  assert_off_needs_long_low_R6: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ != ST_SHUT && !evt.longLow) |=> (stateQ != ST_SHUT));

endmodule

// File: rtl/ctrl_mode_detect.sv
module ctrl_mode_detect
  import ctrl_mode_pkg::*;
#(
  parameter int unsigned CLK_HZ = 1000000,
  parameter int unsigned DLY_US = 100,
  parameter int unsigned DET_US = 260,
  parameter int unsigned WIN_US = 1000,
  parameter int unsigned OFF_US = 2500
) (
  input  logic clk,
  input  logic rstN,
  input  logic ctrlIn,
  output logic devEnable,
  output logic modeWire,
  output logic rxEnable
);

  pinEvt_t evt;
  pinCmd_t cmd;

  ctrlpin_timer #(
    .CLK_HZ(CLK_HZ), .DLY_US(DLY_US), .DET_US(DET_US),
    .WIN_US(WIN_US), .OFF_US(OFF_US), .SYNC_STAGES(2)
  ) uTimer (
    .clk(clk), .rstN(rstN), .ctrlIn(ctrlIn), .cmd(cmd), .evt(evt)
  );

  ctrlpin_fsm uFsm (
    .clk(clk), .rstN(rstN), .evt(evt), .cmd(cmd),
    .devEnable(devEnable), .modeWire(modeWire), .rxEnable(rxEnable)
  );

endmodule

// File: tb/sim_ctrl_mode_detect.sv
`timescale 1ns/1ps
module sim_ctrl_mode_detect;

  localparam int CLK_PERIOD = 1000;   // 1 MHz, one cycle per microsecond
  localparam int DLY = 100, DET = 260, WIN = 1000, OFF = 2500;

  logic clk = 1'b0, rstN = 1'b0, ctrlIn = 1'b0;
  logic devEnable, modeWire, rxEnable;
  int checks = 0, failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctrl_mode_detect #(.CLK_HZ(1000000)) u0 (
    .clk(clk), .rstN(rstN), .ctrlIn(ctrlIn),
    .devEnable(devEnable), .modeWire(modeWire), .rxEnable(rxEnable)
  );

  // timestamp reference model: 0 off, 1 window, 2 pulse-width, 3 serial
  int st, n, tOn, lowLen;
  bit qualOk, mS1, mL, mP;
  always @(posedge clk) begin
    if (!rstN) begin
      st = 0; n = 0; tOn = 0; lowLen = 0; qualOk = 0; mS1 = 0; mL = 0; mP = 0;
    end else begin
      int age;
      bit riseNow, fallNow, hit, longLow, winOver, opened;
      n++;
      age     = n - tOn - 1;
      riseNow = mL && !mP;
      fallNow = !mL && mP;
      longLow = !mL && lowLen >= OFF;
      hit     = qualOk && !mL && lowLen > DET && age < WIN;
      winOver = age >= WIN;
      opened  = 0;
      case (st)
        0: if (riseNow) begin st = 1; tOn = n; opened = 1; end
        1: if (longLow) st = 0; else if (hit) st = 3; else if (winOver) st = 2;
        default: if (longLow) st = 0;
      endcase
      if (opened) qualOk = 0;
      else if (fallNow) qualOk = (age >= DLY);
      lowLen = mL ? 0 : lowLen + 1;
      mP = mL; mL = mS1; mS1 = ctrlIn;
    end
  end

  // continuous comparison against the model
  always @(negedge clk) begin
    if (rstN && !done) begin
      checks++;
      if (devEnable !== (st != 0)) begin
        failures++;
        $display("FAIL R1 model devEnable got %0b expected %0b at cycle %0d", devEnable, st != 0, n);
      end
      if (modeWire !== (st == 3)) begin
        failures++;
        $display("FAIL R3 model modeWire got %0b expected %0b at cycle %0d", modeWire, st == 3, n);
      end
      if (rxEnable !== (st == 3)) begin
        failures++;
        $display("FAIL R7 model rxEnable got %0b expected %0b at cycle %0d", rxEnable, st == 3, n);
      end
    end
  end

  task automatic hold(input bit v, input int cyc);
    ctrlIn = v;
    repeat (cyc) @(negedge clk);
  endtask

  task automatic chk(input bit en, input bit wr, input string tag);
    checks++;
    if (devEnable !== en || modeWire !== wr || rxEnable !== wr) begin
      failures++;
      $display("FAIL %s got en=%0b wire=%0b rx=%0b expected en=%0b wire=%0b rx=%0b",
               tag, devEnable, modeWire, rxEnable, en, wr, wr);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    chk(0, 0, "R1 reset state");
    rstN = 1'b1;
    hold(0, 10);   chk(0, 0, "R1 low line stays off");
    hold(1, 500);  chk(1, 0, "R1 rise enables");
    hold(1, 600);  chk(1, 0, "R4 steady high gives pulse-width");
    hold(0, 400);  chk(1, 0, "R5 late qualifying low ignored");
    hold(0, 1600); chk(1, 0, "R6 2000us low keeps device on");
    hold(1, 10);
    hold(0, 2600); chk(0, 0, "R6 long low turns off");
    // serial selection
    hold(1, 150);  hold(0, 280); chk(1, 1, "R3 serial selected inside window");
    hold(1, 50);
    for (int i = 0; i < 20; i++) begin hold(0, 30); hold(1, 60); end
    chk(1, 1, "R7 short bits keep serial mode");
    hold(0, 2600); chk(0, 0, "R6 turn off from serial");
    // latency and restart default
    hold(1, 2);    chk(0, 0, "R9 not yet on after two edges");
    hold(1, 1);    chk(1, 0, "R9 on after third edge");
    hold(1, 1200); chk(1, 0, "R5 restart defaults to pulse-width");
    hold(0, 2600); chk(0, 0, "R6 off again");
    // early low must not count
    hold(1, 20); hold(0, 400); hold(1, 1200);
    chk(1, 0, "R8 low before delay ignored");
    hold(0, 2600);
    // boundary on detection length
    hold(1, 150); hold(0, 255); hold(1, 1000);
    chk(1, 0, "R3 255us low too short");
    hold(0, 2600);
    hold(1, 150); hold(0, 280);
    chk(1, 1, "R3 280us low selects serial");
    hold(0, 2600);
    // pulse starting near the window end
    hold(1, 900); hold(0, 300); hold(1, 10);
    chk(1, 0, "R4 low cut by window end");
    hold(1, 20);  chk(1, 0, "R2 window closed stays pulse-width");
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule